// File: doc/BRIEF.md
# Circular Interrupt Event Queue Writer

This block sits between a cell-processing engine and a host processor. The engine reports exception events for a channel and one of its subchannels. The block filters each event type against that channel's mask bits. It then packs the surviving flags, an 8-bit subchannel identifier and a 16-bit channel code into one 32-bit entry, and stores the entry in a circular table in a shared dual-port RAM. The block drives one RAM port. The host drives the other, where it reads entries and clears their valid flags.

Each table slot holds its own ownership flag and its own ring-end marker. The block reads the slot at its write pointer before it writes anything. It writes only into a free slot and keeps the slot's existing wrap marker. When the write completes it raises a level interrupt request to the host. If the slot is still pending, the event is lost and a sticky overflow flag is set. A transmit-not-ready event carries the subchannel ID most recently latched for that channel, not the ID on the event bus.

The block accepts one event bundle at a time. `ev_ready` is low while a read and write to the table is in progress. All flags raised in one accepted bundle go into a single entry.

Top module: `iq_event_writer`

## Requirements
- R1: A written entry has this layout, with bit 31 as the most significant bit of the word. Bit 31 is valid and is always 1. Bit 30 is 0. Bit 29 is wrap. Bits 28:21 hold the subchannel ID. Bit 20 is transmit-not-ready, bit 19 receive-buffer, bit 18 busy, bit 17 transmit-buffer and bit 16 receive-frame. Bits 15:0 hold the channel code.
- R2: A slot whose bit 31 reads 1 is never written. In that case the event is dropped, `overflow` goes high and stays high until reset, and the write pointer does not move.
- R3: The wrap bit written back equals the wrap bit read from the slot. After a slot with wrap set is written, the next write goes to slot 0. After any other slot, the next write goes to the following slot.
- R4: Transmit-not-ready is recorded only when `mask_tnr[chan]` is 1. Its entry carries the subchannel ID of the last accepted event on that channel that did not have transmit-not-ready raised, or 0 if there has been none. A transmit-not-ready event does not update that latched ID.
- R5: Receive-buffer is recorded only when `ev_rxb_ibit` and `mask_rxb[chan]` are both 1. Transmit-buffer is recorded only when `ev_txb_ibit` and `mask_txb[chan]` are both 1.
- R6: Receive-frame is recorded only when `mask_rxf[chan]` is 1. Busy is always recorded.
- R7: An accepted event with no flag left after masking writes no entry and does not change `irq`.
- R8: Several flags in one accepted event produce exactly one entry with all of those flag bits set.
- R9: `irq` rises in the cycle after an entry is written. It stays high until an `irq_clr` pulse arrives. A write in the same cycle as `irq_clr` takes priority.
- R10: After reset, `ev_ready` is 1, `irq` and `overflow` are 0, and the write pointer is slot 0. `ev_ready` is 0 while an accepted event is being processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event bundle present |
| ev_ready | output | 1 | Block can accept an event |
| ev_chan | input | CH_W | Channel index, selects mask bits |
| ev_sub | input | 8 | Subchannel identifier |
| ev_code | input | 16 | Channel code |
| ev_tnr | input | 1 | Transmit descriptor not ready |
| ev_rxb | input | 1 | Receive buffer closed |
| ev_rxb_ibit | input | 1 | Receive descriptor interrupt bit |
| ev_busy | input | 1 | Packets discarded, receive table busy |
| ev_txb | input | 1 | Transmit buffer done |
| ev_txb_ibit | input | 1 | Transmit descriptor interrupt bit |
| ev_rxf | input | 1 | Receive frame completed |
| mask_tnr | input | NUM_CH | Per-channel not-ready enable |
| mask_rxb | input | NUM_CH | Per-channel receive-buffer enable |
| mask_txb | input | NUM_CH | Per-channel transmit-buffer enable |
| mask_rxf | input | NUM_CH | Per-channel receive-frame enable |
| mem_rd_en | output | 1 | Table read strobe, data returns the next cycle |
| mem_wr_en | output | 1 | Table write strobe |
| mem_addr | output | AW | Slot index |
| mem_wr_data | output | 32 | Entry written |
| mem_rd_data | input | 32 | Slot contents read |
| irq | output | 1 | Interrupt request to host |
| irq_clr | input | 1 | One-cycle acknowledge |
| overflow | output | 1 | Sticky lost-event flag |

## Verification
The bench builds the block with an 8-slot table and 4 channels. The default is 64 slots and 16 channels. With 8 slots, a short directed sequence fills the ring up to the slot that carries the wrap marker. The next event then finds slot 0 still pending, so the wrap return and the overflow drop are both tested. After the host clears slot 0, the retried write lands there. The 4 channels let each mask kind be tested on a different channel, and let the latched subchannel ID be followed on one channel while the others change.

// File: rtl/iq_pkg.sv
package iq_pkg;

    localparam int ENTRY_W   = 32;
    localparam int VALID_POS = 31;
    localparam int WRAP_POS  = 29;

    typedef struct packed {
        logic tnr;
        logic rxb;
        logic busy;
        logic txb;
        logic rxf;
    } iq_flags_t;

    typedef struct packed {
        logic [7:0]  sub;
        iq_flags_t   flags;
        logic [15:0] code;
    } iq_event_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_CHECK
    } iq_state_e;

    function automatic logic [ENTRY_W-1:0] iq_pack(input logic wrap, input iq_event_t e);
        return {1'b1, 1'b0, wrap, e.sub, e.flags, e.code};
    endfunction

endpackage

// File: rtl/iq_event_gate.sv
module iq_event_gate
    import iq_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [CH_W-1:0]   chan,
    input  logic [7:0]        sub,
    input  logic [15:0]       code,
    input  logic              raw_tnr,
    input  logic              raw_rxb,
    input  logic              raw_rxb_ibit,
    input  logic              raw_busy,
    input  logic              raw_txb,
    input  logic              raw_txb_ibit,
    input  logic              raw_rxf,
    input  logic [NUM_CH-1:0] en_tnr,
    input  logic [NUM_CH-1:0] en_rxb,
    input  logic [NUM_CH-1:0] en_txb,
    input  logic [NUM_CH-1:0] en_rxf,
    output iq_event_t         evt,
    output logic              hit
);

    logic [7:0] last_sub_q [NUM_CH];
    logic [7:0] last_sub_d [NUM_CH];
    iq_flags_t  flags;

    always_comb begin
        flags.tnr  = raw_tnr & en_tnr[chan];
        flags.rxb  = raw_rxb & raw_rxb_ibit & en_rxb[chan];
        flags.busy = raw_busy;
        flags.txb  = raw_txb & raw_txb_ibit & en_txb[chan];
        flags.rxf  = raw_rxf & en_rxf[chan];

        evt.flags = flags;
        evt.code  = code;
        evt.sub   = raw_tnr ? last_sub_q[chan] : sub;
        hit       = |flags;

        for (int i = 0; i < NUM_CH; i++) begin
            last_sub_d[i] = last_sub_q[i];
        end
        if (accept && !raw_tnr) begin
            last_sub_d[chan] = sub;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                last_sub_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                last_sub_q[i] <= last_sub_d[i];
            end
        end
    end

endmodule

// File: rtl/iq_slot_writer.sv
module iq_slot_writer
    import iq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_valid,
    input  logic               hit,
    input  iq_event_t          evt,
    output logic               ev_ready,
    output logic               mem_rd_en,
    output logic               mem_wr_en,
    output logic [AW-1:0]      mem_addr,
    output logic [ENTRY_W-1:0] mem_wr_data,
    input  logic               slot_valid,
    input  logic               slot_wrap,
    input  logic               irq_clr,
    output logic               irq,
    output logic               overflow
);

    localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

    typedef struct packed {
        iq_state_e   st;
        logic [AW-1:0] wptr;
        iq_event_t   entry;
        logic        irq;
        logic        ovf;
    } wr_state_t;

    wr_state_t s_q, s_d;

    always_comb begin
        s_d         = s_q;
        ev_ready    = (s_q.st == ST_IDLE);
        mem_rd_en   = 1'b0;
        mem_wr_en   = 1'b0;
        mem_addr    = s_q.wptr;
        mem_wr_data = iq_pack(slot_wrap, s_q.entry);

        if (irq_clr) begin
            s_d.irq = 1'b0;
        end

        unique case (s_q.st)
            ST_IDLE: begin
                if (ev_valid && hit) begin
                    s_d.entry = evt;
                    s_d.st    = ST_READ;
                end
            end
            ST_READ: begin
                mem_rd_en = 1'b1;
                s_d.st    = ST_CHECK;
            end
            ST_CHECK: begin
                s_d.st = ST_IDLE;
                if (slot_valid) begin
                    s_d.ovf = 1'b1;
                end else begin
                    mem_wr_en = 1'b1;
                    s_d.irq   = 1'b1;
                    if (slot_wrap || s_q.wptr == LAST_SLOT) begin
                        s_d.wptr = '0;
                    end else begin
                        s_d.wptr = s_q.wptr + 1'b1;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st    <= ST_IDLE;
            s_q.wptr  <= '0;
            s_q.entry <= '0;
            s_q.irq   <= 1'b0;
            s_q.ovf   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq      = s_q.irq;
    assign overflow = s_q.ovf;

endmodule

// File: rtl/iq_event_writer.sv
module iq_event_writer
    import iq_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int DEPTH  = 64,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [CH_W-1:0]   ev_chan,
    input  logic [7:0]        ev_sub,
    input  logic [15:0]       ev_code,
    input  logic              ev_tnr,
    input  logic              ev_rxb,
    input  logic              ev_rxb_ibit,
    input  logic              ev_busy,
    input  logic              ev_txb,
    input  logic              ev_txb_ibit,
    input  logic              ev_rxf,
    input  logic [NUM_CH-1:0] mask_tnr,
    input  logic [NUM_CH-1:0] mask_rxb,
    input  logic [NUM_CH-1:0] mask_txb,
    input  logic [NUM_CH-1:0] mask_rxf,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wr_data,
    input  logic [31:0]       mem_rd_data,
    output logic              irq,
    input  logic              irq_clr,
    output logic              overflow
);

    iq_event_t evt;
    logic      hit;
    logic      accept;

    assign accept = ev_valid & ev_ready;

    iq_event_gate #(.NUM_CH(NUM_CH), .CH_W(CH_W)) gate_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .chan         (ev_chan),
        .sub          (ev_sub),
        .code         (ev_code),
        .raw_tnr      (ev_tnr),
        .raw_rxb      (ev_rxb),
        .raw_rxb_ibit (ev_rxb_ibit),
        .raw_busy     (ev_busy),
        .raw_txb      (ev_txb),
        .raw_txb_ibit (ev_txb_ibit),
        .raw_rxf      (ev_rxf),
        .en_tnr       (mask_tnr),
        .en_rxb       (mask_rxb),
        .en_txb       (mask_txb),
        .en_rxf       (mask_rxf),
        .evt          (evt),
        .hit          (hit)
    );

    iq_slot_writer #(.DEPTH(DEPTH), .AW(AW)) writer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_valid    (ev_valid),
        .hit         (hit),
        .evt         (evt),
        .ev_ready    (ev_ready),
        .mem_rd_en   (mem_rd_en),
        .mem_wr_en   (mem_wr_en),
        .mem_addr    (mem_addr),
        .mem_wr_data (mem_wr_data),
        .slot_valid  (mem_rd_data[VALID_POS]),
        .slot_wrap   (mem_rd_data[WRAP_POS]),
        .irq_clr     (irq_clr),
        .irq         (irq),
        .overflow    (overflow)
    );

endmodule

// File: rtl/iq_event_writer_chk.sv
module iq_event_writer_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ev_valid,
    input logic          ev_ready,
    input logic          ev_busy,
    input logic          mem_rd_en,
    input logic          mem_wr_en,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wr_data,
    input logic [31:0]   mem_rd_data,
    input logic          irq,
    input logic          overflow
);

    p_rd_wr_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    p_valid_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_wr_data[31] && !mem_wr_data[30]));

    p_no_overwrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> !mem_rd_data[31]);

    p_overflow_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    p_wrap_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_wr_data[29] == mem_rd_data[29]));

    p_write_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($past(mem_rd_en) && mem_addr == $past(mem_addr)));

    p_busy_reported_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready && ev_busy) |=> mem_rd_en);

    p_irq_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> irq);

endmodule

bind iq_event_writer iq_event_writer_chk #(.AW(AW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_valid    (ev_valid),
    .ev_ready    (ev_ready),
    .ev_busy     (ev_busy),
    .mem_rd_en   (mem_rd_en),
    .mem_wr_en   (mem_wr_en),
    .mem_addr    (mem_addr),
    .mem_wr_data (mem_wr_data),
    .mem_rd_data (mem_rd_data),
    .irq         (irq),
    .overflow    (overflow)
);

// File: tb/iq_event_writer_tb_top.sv
`timescale 1ns/1ps
module iq_event_writer_tb_top;

    localparam int NUM_CH = 4;
    localparam int DEPTH  = 8;
    localparam int CH_W   = 2;
    localparam int AW     = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              ev_valid = 0, ev_ready;
    logic [CH_W-1:0]   ev_chan = 0;
    logic [7:0]        ev_sub = 0;
    logic [15:0]       ev_code = 0;
    logic ev_tnr = 0, ev_rxb = 0, ev_rxb_ibit = 0, ev_busy = 0;
    logic ev_txb = 0, ev_txb_ibit = 0, ev_rxf = 0;
    logic [NUM_CH-1:0] mask_tnr = 0, mask_rxb = 0, mask_txb = 0, mask_rxf = 0;
    logic              mem_rd_en, mem_wr_en;
    logic [AW-1:0]     mem_addr;
    logic [31:0]       mem_wr_data;
    logic [31:0]       mem_rd_data;
    logic              irq, overflow;
    logic              irq_clr = 0;

    logic              host_clr_en = 0;
    logic [AW-1:0]     host_clr_idx = 0;
    logic [31:0]       mem [DEPTH];

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    iq_event_writer #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_chan(ev_chan), .ev_sub(ev_sub), .ev_code(ev_code),
        .ev_tnr(ev_tnr), .ev_rxb(ev_rxb), .ev_rxb_ibit(ev_rxb_ibit),
        .ev_busy(ev_busy), .ev_txb(ev_txb), .ev_txb_ibit(ev_txb_ibit),
        .ev_rxf(ev_rxf), .mask_tnr(mask_tnr), .mask_rxb(mask_rxb),
        .mask_txb(mask_txb), .mask_rxf(mask_rxf), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wr_data(mem_wr_data),
        .mem_rd_data(mem_rd_data), .irq(irq), .irq_clr(irq_clr),
        .overflow(overflow)
    );

    // Dual-port table: block port plus host clear port
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= (i == DEPTH - 1) ? 32'h2000_0000 : 32'h0;
            end
            mem_rd_data <= '0;
        end else begin
            if (mem_rd_en) mem_rd_data <= mem[mem_addr];
            if (mem_wr_en) mem[mem_addr] <= mem_wr_data;
            if (host_clr_en) mem[host_clr_idx][31] <= 1'b0;
        end
    end

    function automatic logic [31:0] expw(input logic wrap, input logic [7:0] sub,
                                         input logic [4:0] fl, input logic [15:0] code);
        return {1'b1, 1'b0, wrap, sub, fl, code};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // flags order: tnr rxb busy txb rxf ; ib = {rxb_ibit, txb_ibit}
    task automatic send(input logic [CH_W-1:0] ch, input logic [7:0] sub,
                        input logic [15:0] code, input logic [4:0] fl,
                        input logic [1:0] ib, input bit chk_ready);
        @(negedge clk);
        ev_chan = ch; ev_sub = sub; ev_code = code;
        {ev_tnr, ev_rxb, ev_busy, ev_txb, ev_rxf} = fl;
        {ev_rxb_ibit, ev_txb_ibit} = ib;
        ev_valid = 1;
        @(posedge clk);
        @(negedge clk);
        ev_valid = 0;
        if (chk_ready) check("R10 ready low while busy", {31'b0, ev_ready}, 32'h0);
        repeat (3) @(negedge clk);
    endtask

    task automatic ack_irq();
        @(negedge clk); irq_clr = 1;
        @(negedge clk); irq_clr = 0;
    endtask

    task automatic host_clear(input logic [AW-1:0] idx);
        @(negedge clk); host_clr_en = 1; host_clr_idx = idx;
        @(negedge clk); host_clr_en = 0;
    endtask

    task automatic t_reset();
        check("R10 ready after reset", {31'b0, ev_ready}, 32'h1);
        check("R10 irq after reset", {31'b0, irq}, 32'h0);
        check("R10 overflow after reset", {31'b0, overflow}, 32'h0);
    endtask

    task automatic t_busy_first();
        send(0, 8'h5A, 16'h1234, 5'b00100, 2'b00, 1);
        check("R1 R6 busy entry slot0", mem[0], expw(0, 8'h5A, 5'b00100, 16'h1234));
        check("R9 irq raised", {31'b0, irq}, 32'h1);
        repeat (3) @(negedge clk);
        check("R9 irq held", {31'b0, irq}, 32'h1);
        ack_irq();
        check("R9 irq cleared", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_masks();
        send(0, 8'h11, 16'h0001, 5'b01000, 2'b10, 0);
        check("R5 R7 rxb masked off", mem[1], 32'h0);
        check("R7 no irq", {31'b0, irq}, 32'h0);
        mask_rxb[0] = 1;
        send(0, 8'h11, 16'h0001, 5'b01000, 2'b00, 0);
        check("R5 rxb ibit clear", mem[1], 32'h0);
        send(0, 8'h11, 16'h0001, 5'b01000, 2'b10, 0);
        check("R5 rxb recorded", mem[1], expw(0, 8'h11, 5'b01000, 16'h0001));
        mask_txb[2] = 1;
        send(2, 8'h22, 16'h0002, 5'b00010, 2'b00, 0);
        check("R5 txb ibit clear", mem[2], 32'h0);
        send(2, 8'h22, 16'h0002, 5'b00010, 2'b01, 0);
        check("R5 txb recorded", mem[2], expw(0, 8'h22, 5'b00010, 16'h0002));
        send(3, 8'h33, 16'h0003, 5'b00001, 2'b00, 0);
        check("R6 rxf masked off", mem[3], 32'h0);
        mask_rxf[3] = 1;
        send(3, 8'h33, 16'h0003, 5'b00001, 2'b00, 0);
        check("R6 rxf recorded", mem[3], expw(0, 8'h33, 5'b00001, 16'h0003));
        ack_irq();
    endtask

    task automatic t_tnr();
        send(1, 8'hAA, 16'h0101, 5'b10000, 2'b00, 0);
        check("R4 tnr masked off", mem[4], 32'h0);
        mask_tnr[1] = 1;
        send(1, 8'hAA, 16'h0101, 5'b10000, 2'b00, 0);
        check("R4 tnr never latched gives 0", mem[4], expw(0, 8'h00, 5'b10000, 16'h0101));
        send(1, 8'h33, 16'h0102, 5'b00100, 2'b00, 0);
        check("R4 busy latches id", mem[5], expw(0, 8'h33, 5'b00100, 16'h0102));
        send(1, 8'h77, 16'h0103, 5'b10000, 2'b00, 0);
        check("R4 tnr uses latched id", mem[6], expw(0, 8'h33, 5'b10000, 16'h0103));
    endtask

    task automatic t_merge_wrap();
        mask_rxf[2] = 1;
        send(2, 8'h44, 16'hBEEF, 5'b00111, 2'b01, 0);
        check("R8 R3 merged entry keeps wrap", mem[7], expw(1, 8'h44, 5'b00111, 16'hBEEF));
        check("R8 single entry only", mem[0], expw(0, 8'h5A, 5'b00100, 16'h1234));
        ack_irq();
    endtask

    task automatic t_overflow();
        send(0, 8'h99, 16'h0999, 5'b00100, 2'b00, 0);
        check("R2 pending slot untouched", mem[0], expw(0, 8'h5A, 5'b00100, 16'h1234));
        check("R2 overflow set", {31'b0, overflow}, 32'h1);
        check("R2 no irq on drop", {31'b0, irq}, 32'h0);
        host_clear(0);
        send(0, 8'h66, 16'h0666, 5'b00100, 2'b00, 0);
        check("R3 R2 retry lands in slot0", mem[0], expw(0, 8'h66, 5'b00100, 16'h0666));
        check("R3 slot1 not written", mem[1], expw(0, 8'h11, 5'b01000, 16'h0001));
        check("R2 overflow sticky", {31'b0, overflow}, 32'h1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1;
        @(negedge clk);
        t_reset();
        t_busy_first();
        t_masks();
        t_tnr();
        t_merge_wrap();
        t_overflow();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule